// File: doc/BRIEF.md
# Stride Adjacency Memory Self-Test Controller

This controller runs a stride-based adjacency test on a synchronous single-port RAM and drives the RAM's ordinary master port. The address range is walked as a ring of stride classes. For each class in turn, the controller first writes a test word into the locations of that class. It then overwrites every other location in the range with the inverted word, and it does this a programmable number of times. Last, it reads back only the locations of that class. Each of these write sweeps and the read sweep covers the whole range separately, one address per clock. Between marking a location and checking it, the controller therefore sweeps the whole range at least twice, so buffering has no effect on the check. Repeated inverted writes to neighbouring cells expose coupling faults and charge-fade faults.

The range runs from a base address to a last address. A location's class is its distance from the base address modulo the stride. That distance comes from a wrapping counter that steps in step with the address, so the design needs no divider. A typical stride is 20. A repeat count of 2 gives the normal run, and a repeat count of 6 gives the long-gap run. When a read-back word differs from the test word, the controller reports the address, the expected word and the observed word for one cycle. It then carries on to the end of the run. A sticky done flag marks completion.

Top module: `stride_mem_tester`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done`, `err_valid` and `mem_en` are all 0.
- R2: A `start` pulse while idle captures the stride, repeat count, test word, base and last address. A `start` while busy is ignored and does not change the run's length or its memory traffic.
- R3: The class offset steps from 0 to S−1, where S is the captured stride. For each offset there is one mark sweep, K inverted sweeps and one read sweep. Each sweep visits base..last in ascending order, one address per cycle. `busy` is high for exactly S·N·(K+2)+1 cycles, where N = last−base+1.
- R4: During the mark sweep for offset o, the controller writes the test word to exactly those addresses whose (address−base) mod S equals o. The first write of a run is the test word at the base address. Over a whole run, each address in the range receives the test word exactly once.
- R5: During an inverted sweep, every address in the range outside the current class is written with the bitwise inverse of the test word. Over a run, each address receives (S−1)·K inverted writes. A repeat count of 0 is treated as 1.
- R6: During the read sweep, only the current class is read, so each address in the range is read exactly once per run. At the end of a run, the members of class S−1 hold the test word and every other address holds its inverse.
- R7: A read-back word that differs from the test word raises `err_valid` for one cycle, two cycles after the read request. `err_addr`, `err_expected` and `err_observed` carry the address, the test word and the word returned. The run still completes with its normal length.
- R8: A stride of 0 is treated as 1. With a stride of 1, every address is a member of the only class, and no inverted writes occur.
- R9: The memory port is never enabled outside base..last, and never enabled while `busy` is low.
- R10: `done` rises in the cycle after the last busy cycle and stays high, with `busy` low, until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (accepted only when idle) |
| cfg_stride | input | STRIDE_W | Stride S (0 treated as 1) |
| cfg_reps | input | REP_W | Inverted sweeps per class K (0 treated as 1) |
| cfg_pattern | input | DATA_W | Test word |
| cfg_base | input | ADDR_W | First address of the range |
| cfg_last | input | ADDR_W | Last address of the range (not below base) |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid the cycle after a read request |
| busy | output | 1 | Run in progress |
| done | output | 1 | Sticky completion flag |
| err_valid | output | 1 | One-cycle mismatch report |
| err_addr | output | ADDR_W | Address of the mismatch |
| err_expected | output | DATA_W | Word expected |
| err_observed | output | DATA_W | Word returned by memory |

## Verification
A wrong class counter or offset would shift which addresses receive the test word. The bench would see this within the first sweep, as a first write away from the base address, or at the end of the run as per-address write and read counts that differ from one and (S−1)·K. A miscounted repeat register or sweep terminator changes the number of busy cycles and the final memory image, so the fault shows at `done`. A misaligned compare stage reports the wrong address or word for an injected coupling or stuck-bit fault, or reports it at the wrong distance from the read request, and the bench sees this two cycles after the faulty read.

// File: rtl/stm_pkg.sv
// Shared types for the stride adjacency memory tester.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package stm_pkg;

    // Phase of the test run; one value per kind of sweep.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MARK = 3'd1,
        ST_FILL = 3'd2,
        ST_READ = 3'd3,
        ST_FIN  = 3'd4
    } stm_state_e;

endpackage

// File: rtl/stm_sweep.sv
// Address walker for one sweep of the range, with a class counter
// that wraps at the stride and runs in lockstep with the address.
// Assumes: base/last/stride_m1 are held stable for the whole run;
// load restarts the sweep at base with class 0.
module stm_sweep #(
    parameter int ADDR_W   = 8,
    parameter int STRIDE_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                run,
    input  logic [ADDR_W-1:0]   base,
    input  logic [ADDR_W-1:0]   last,
    input  logic [STRIDE_W-1:0] stride_m1,
    output logic [ADDR_W-1:0]   addr,
    output logic [STRIDE_W-1:0] phase,
    output logic                at_end
);

    // Sweep terminates when the last address is being visited.
    assign at_end = (addr == last);

    // Advance address and wrapping class counter one step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            phase <= '0;
        end else if (load) begin
            addr  <= base;
            phase <= '0;
        end else if (run) begin
            addr  <= addr + 1'b1;
            phase <= (phase == stride_m1) ? '0 : phase + 1'b1;
        end
    end

    // The class counter never exceeds the stride limit.
    assert_phase_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        phase <= stride_m1);

    // Inside a sweep the address climbs by one per cycle.
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/stm_sequencer.sv
// Run controller: captures the configuration, steps the class offset
// and the inverted-sweep repeat count, and orders the sweeps
// mark -> fill x K -> read for each offset.
// Assumes: sweep_end comes from the sweep walker and is meaningful only
// in the sweeping phases; start is ignored unless idle.
module stm_sequencer
    import stm_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int STRIDE_W = 6,
    parameter int REP_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [REP_W-1:0]    cfg_reps,
    input  logic [DATA_W-1:0]   cfg_pattern,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [ADDR_W-1:0]   cfg_last,
    input  logic                sweep_end,
    output stm_state_e          state,
    output logic [STRIDE_W-1:0] offset,
    output logic [STRIDE_W-1:0] stride_m1,
    output logic [ADDR_W-1:0]   base_q,
    output logic [ADDR_W-1:0]   last_q,
    output logic [DATA_W-1:0]   pat_q,
    output logic                sweep_load,
    output logic                sweeping,
    output logic                busy,
    output logic                done
);

    logic [REP_W-1:0] reps_q;
    logic [REP_W-1:0] rep_cnt;

    // Decode phase-level status for the walker and the port.
    always_comb begin
        sweeping   = (state == ST_MARK) || (state == ST_FILL) || (state == ST_READ);
        busy       = (state != ST_IDLE);
        sweep_load = ((state == ST_IDLE) && start) || (sweeping && sweep_end);
    end

    // Phase, offset and repeat bookkeeping for the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            offset    <= '0;
            stride_m1 <= '0;
            reps_q    <= '0;
            rep_cnt   <= '0;
            base_q    <= '0;
            last_q    <= '0;
            pat_q     <= '0;
            done      <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        stride_m1 <= (cfg_stride == '0) ? '0 : cfg_stride - 1'b1;
                        reps_q    <= (cfg_reps == '0) ? REP_W'(1) : cfg_reps;
                        base_q    <= cfg_base;
                        last_q    <= cfg_last;
                        pat_q     <= cfg_pattern;
                        offset    <= '0;
                        done      <= 1'b0;
                        state     <= ST_MARK;
                    end
                end
                ST_MARK: begin
                    if (sweep_end) begin
                        rep_cnt <= REP_W'(1);
                        state   <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (sweep_end) begin
                        if (rep_cnt == reps_q) begin
                            state <= ST_READ;
                        end else begin
                            rep_cnt <= rep_cnt + 1'b1;
                        end
                    end
                end
                ST_READ: begin
                    if (sweep_end) begin
                        if (offset == stride_m1) begin
                            state <= ST_FIN;
                        end else begin
                            offset <= offset + 1'b1;
                            state  <= ST_MARK;
                        end
                    end
                end
                ST_FIN: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // The class offset never passes the last class.
    assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        offset <= stride_m1);

    // The repeat counter stays within 1..K while filling.
    assert_rep_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL) |-> (rep_cnt >= REP_W'(1) && rep_cnt <= reps_q));

    // Completion is only flagged while idle.
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (state == ST_IDLE));

    // Configuration is frozen once a run is under way.
    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(pat_q) && $stable(stride_m1) && $stable(base_q)));

endmodule

// File: rtl/stm_checker.sv
// Read-back compare stage: remembers the address of a read request,
// compares the word returned one cycle later, and registers a one-cycle
// mismatch report with address, expected and observed words.
// Assumes: memory returns read data in the cycle after the request;
// the expected word is stable during the run.
module stm_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] expect_word,
    input  logic [DATA_W-1:0] rdata,
    output logic              err_valid,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_expected,
    output logic [DATA_W-1:0] err_observed
);

    logic              pend;
    logic [ADDR_W-1:0] pend_addr;

    // Track the outstanding read for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_addr <= '0;
        end else begin
            pend      <= rd_issue;
            pend_addr <= rd_addr;
        end
    end

    // Compare returned data and latch a report on mismatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_valid    <= 1'b0;
            err_addr     <= '0;
            err_expected <= '0;
            err_observed <= '0;
        end else begin
            err_valid <= pend && (rdata != expect_word);
            if (pend && (rdata != expect_word)) begin
                err_addr     <= pend_addr;
                err_expected <= expect_word;
                err_observed <= rdata;
            end
        end
    end

    // A report is only ever the result of a read two cycles earlier.
    assert_err_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> $past(pend));

    // A reported mismatch never carries equal words.
    assert_err_differs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid |-> (err_expected != err_observed));

endmodule

// File: rtl/stride_mem_tester.sv
// Stride adjacency memory self-test controller. Joins the sequencer,
// the sweep walker and the compare stage, and forms the memory
// master port from the current phase and class membership.
// Assumes: single-port synchronous RAM with one-cycle read latency;
// cfg_last >= cfg_base.
module stride_mem_tester
    import stm_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 16,
    parameter int STRIDE_W = 6,
    parameter int REP_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [REP_W-1:0]    cfg_reps,
    input  logic [DATA_W-1:0]   cfg_pattern,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [ADDR_W-1:0]   cfg_last,
    output logic                mem_en,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic                busy,
    output logic                done,
    output logic                err_valid,
    output logic [ADDR_W-1:0]   err_addr,
    output logic [DATA_W-1:0]   err_expected,
    output logic [DATA_W-1:0]   err_observed
);

    stm_state_e          state;
    logic [STRIDE_W-1:0] offset;
    logic [STRIDE_W-1:0] stride_m1;
    logic [ADDR_W-1:0]   base_q;
    logic [ADDR_W-1:0]   last_q;
    logic [DATA_W-1:0]   pat_q;
    logic                sweep_load;
    logic                sweeping;
    logic [ADDR_W-1:0]   sw_addr;
    logic [STRIDE_W-1:0] sw_phase;
    logic                sw_end;
    logic                member;
    logic                rd_issue;

    stm_sequencer #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRIDE_W(STRIDE_W), .REP_W(REP_W)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_stride(cfg_stride), .cfg_reps(cfg_reps), .cfg_pattern(cfg_pattern),
        .cfg_base(cfg_base), .cfg_last(cfg_last),
        .sweep_end(sw_end),
        .state(state), .offset(offset), .stride_m1(stride_m1),
        .base_q(base_q), .last_q(last_q), .pat_q(pat_q),
        .sweep_load(sweep_load), .sweeping(sweeping),
        .busy(busy), .done(done)
    );

    stm_sweep #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W)
    ) u_sweep (
        .clk(clk), .rst_n(rst_n), .load(sweep_load), .run(sweeping),
        .base(sweep_load && !sweeping ? cfg_base : base_q),
        .last(last_q), .stride_m1(stride_m1),
        .addr(sw_addr), .phase(sw_phase), .at_end(sw_end)
    );

    // Drive the memory port from phase and class membership.
    always_comb begin
        member    = (sw_phase == offset);
        mem_addr  = sw_addr;
        mem_wdata = (state == ST_MARK) ? pat_q : ~pat_q;
        mem_we    = (state == ST_MARK) || (state == ST_FILL);
        mem_en    = ((state == ST_MARK) && member) ||
                    ((state == ST_FILL) && !member) ||
                    ((state == ST_READ) && member);
        rd_issue  = (state == ST_READ) && member;
    end

    stm_checker #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_chk (
        .clk(clk), .rst_n(rst_n), .rd_issue(rd_issue), .rd_addr(sw_addr),
        .expect_word(pat_q), .rdata(mem_rdata),
        .err_valid(err_valid), .err_addr(err_addr),
        .err_expected(err_expected), .err_observed(err_observed)
    );

    // The memory port is quiet whenever no run is in progress.
    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);

    // Accesses stay within the captured range.
    assert_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> (mem_addr >= base_q && mem_addr <= last_q));

endmodule

// File: tb/tb_stride_mem_tester.sv
module tb_stride_mem_tester;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int SW = 6;
    localparam int RW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [SW-1:0] cfg_stride = '0;
    logic [RW-1:0] cfg_reps = '0;
    logic [DW-1:0] cfg_pattern = '0;
    logic [AW-1:0] cfg_base = '0;
    logic [AW-1:0] cfg_last = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, err_valid;
    logic [AW-1:0] err_addr;
    logic [DW-1:0] err_expected, err_observed;

    stride_mem_tester #(.ADDR_W(AW), .DATA_W(DW), .STRIDE_W(SW), .REP_W(RW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cfg_stride(cfg_stride), .cfg_reps(cfg_reps), .cfg_pattern(cfg_pattern),
        .cfg_base(cfg_base), .cfg_last(cfg_last),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .busy(busy), .done(done), .err_valid(err_valid), .err_addr(err_addr),
        .err_expected(err_expected), .err_observed(err_observed)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Memory model with optional coupling and stuck-bit faults.
    logic [DW-1:0] mem [256];
    int agg = -1, vic = -1, stk = -1;
    logic [DW-1:0] stk_mask = '0;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                if (agg >= 0 && int'(mem_addr) == agg) mem[vic] <= mem_wdata;
            end else begin
                mem_rdata <= (stk >= 0 && int'(mem_addr) == stk) ?
                             (mem[mem_addr] | stk_mask) : mem[mem_addr];
            end
        end
    end

    // Port monitor, sampled on the falling edge.
    int wp [256];
    int wc [256];
    int rd [256];
    int busy_cyc, oor, bad_wr, errs, idle_acc, cyc, rd_cyc, err_cyc;
    int first_addr;
    logic [DW-1:0] first_data;
    logic [AW-1:0] e_addr;
    logic [DW-1:0] e_exp, e_obs;
    logic mon_on = 1'b0;
    logic [DW-1:0] m_pat;
    int m_base, m_last;

    always @(negedge clk) begin
        cyc++;
        if (mon_on) begin
            if (busy) busy_cyc++;
            if (!busy && mem_en) idle_acc++;
            if (mem_en) begin
                if (int'(mem_addr) < m_base || int'(mem_addr) > m_last) oor++;
                if (mem_we) begin
                    if (first_addr < 0) begin
                        first_addr = int'(mem_addr);
                        first_data = mem_wdata;
                    end
                    if (mem_wdata == m_pat) wp[mem_addr]++;
                    else if (mem_wdata == ~m_pat) wc[mem_addr]++;
                    else bad_wr++;
                end else begin
                    rd[mem_addr]++;
                    if (int'(mem_addr) == vic || int'(mem_addr) == stk) rd_cyc = cyc;
                end
            end
            if (err_valid) begin
                errs++;
                err_cyc = cyc;
                e_addr = err_addr;
                e_exp = err_expected;
                e_obs = err_observed;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Run one test to completion, returning once done is seen.
    task automatic run(input int s, input int k, input logic [DW-1:0] p,
                       input int b, input int l, output bit ok);
        for (int i = 0; i < 256; i++) begin
            wp[i] = 0; wc[i] = 0; rd[i] = 0;
        end
        busy_cyc = 0; oor = 0; bad_wr = 0; errs = 0; idle_acc = 0;
        first_addr = -1; rd_cyc = -1; err_cyc = -1;
        m_pat = p; m_base = b; m_last = l;
        @(negedge clk);
        cfg_stride = SW'(s); cfg_reps = RW'(k); cfg_pattern = p;
        cfg_base = AW'(b); cfg_last = AW'(l);
        start = 1'b1; mon_on = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ok = 1'b0;
        for (int i = 0; i < 30000; i++) begin
            if (done) begin
                ok = 1'b1;
                break;
            end
            @(negedge clk);
        end
        mon_on = 1'b0;
        check(ok, "R10", "done within limit", ok, 1);
    endtask

    // Per-address traffic and final image against the requirement formulas.
    task automatic check_traffic(input int s, input int k, input int b, input int l,
                                 input logic [DW-1:0] p);
        int se = (s == 0) ? 1 : s;
        int ke = (k == 0) ? 1 : k;
        int n = l - b + 1;
        int bp = 0, bc = 0, br = 0, bm = 0;
        for (int a = b; a <= l; a++) begin
            logic [DW-1:0] ex;
            ex = (((a - b) % se) == se - 1) ? p : ~p;
            if (wp[a] != 1) bp++;
            if (wc[a] != (se - 1) * ke) bc++;
            if (rd[a] != 1) br++;
            if (mem[a] != ex) bm++;
        end
        check(busy_cyc == se * n * (ke + 2) + 1, "R3", "busy cycles", busy_cyc, se * n * (ke + 2) + 1);
        check(bp == 0 && bad_wr == 0, "R4", "addresses without one mark write", bp, 0);
        check(bc == 0, "R5", "addresses with wrong inverted write count", bc, 0);
        check(br == 0, "R6", "addresses without one read", br, 0);
        check(bm == 0, "R6", "final image mismatches", bm, 0);
        check(oor == 0 && idle_acc == 0, "R9", "accesses outside range or idle", oor + idle_acc, 0);
        check(first_addr == b && first_data == p, "R4", "first write address", first_addr, b);
    endtask

    task automatic t_reset();
        check(busy == 0, "R1", "busy after reset", busy, 0);
        check(done == 0, "R1", "done after reset", done, 0);
        check(err_valid == 0, "R1", "err_valid after reset", err_valid, 0);
        check(mem_en == 0, "R1", "mem_en after reset", mem_en, 0);
    endtask

    task automatic t_normal();
        bit ok;
        run(20, 2, 16'hA5C3, 0, 63, ok);
        check_traffic(20, 2, 0, 63, 16'hA5C3);
        check(errs == 0, "R7", "errors on clean memory", errs, 0);
        repeat (3) @(negedge clk);
        check(done == 1 && busy == 0, "R10", "done held while idle", {done, busy}, 2'b10);
    endtask

    task automatic t_extended();
        bit ok;
        run(5, 6, 16'h0F0F, 0, 39, ok);
        check_traffic(5, 6, 0, 39, 16'h0F0F);
        check(errs == 0, "R5", "errors with six inverted sweeps", errs, 0);
    endtask

    task automatic t_reps_zero();
        bit ok;
        run(4, 0, 16'h1357, 0, 15, ok);
        check_traffic(4, 0, 0, 15, 16'h1357);
    endtask

    task automatic t_stride_zero_one();
        bit ok;
        run(0, 1, 16'h8001, 0, 7, ok);
        check_traffic(0, 1, 0, 7, 16'h8001);
        check(wc[3] == 0, "R8", "stride 0 inverted writes", wc[3], 0);
        run(1, 2, 16'h7FFE, 2, 9, ok);
        check_traffic(1, 2, 2, 9, 16'h7FFE);
    endtask

    task automatic t_base_and_start_ignored();
        bit ok;
        fork
            run(7, 2, 16'h3C3C, 10, 49, ok);
            begin
                repeat (60) @(negedge clk);
                cfg_stride = SW'(3); cfg_base = AW'(0); start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        check_traffic(7, 2, 10, 49, 16'h3C3C);
        check(busy_cyc == 7 * 40 * 4 + 1, "R2", "start while busy ignored", busy_cyc, 7 * 40 * 4 + 1);
    endtask

    task automatic t_coupling();
        bit ok;
        agg = 9; vic = 10;
        run(4, 2, 16'h00FF, 0, 31, ok);
        check(errs == 1, "R7", "coupling error count", errs, 1);
        check(e_addr == 10, "R7", "error address", e_addr, 10);
        check(e_exp == 16'h00FF && e_obs == 16'hFF00, "R7", "error words", {e_exp, e_obs}, 32'h00FF_FF00);
        check(err_cyc - rd_cyc == 2, "R7", "report latency", err_cyc - rd_cyc, 2);
        check(busy_cyc == 4 * 32 * 4 + 1, "R7", "run continues after error", busy_cyc, 4 * 32 * 4 + 1);
        agg = -1; vic = -1;
    endtask

    task automatic t_stuck();
        bit ok;
        stk = 5; stk_mask = 16'h0008;
        run(8, 1, 16'h1234, 0, 15, ok);
        check(errs == 1, "R7", "stuck-bit error count", errs, 1);
        check(e_addr == 5 && e_obs == 16'h123C, "R7", "stuck-bit report", {e_addr, e_obs}, {8'd5, 16'h123C});
        stk = -1; stk_mask = '0;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_extended();
        t_reps_zero();
        t_stride_zero_one();
        t_base_and_start_ignored();
        t_coupling();
        t_stuck();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule